// File: doc/BRIEF.md
# Arithmetic Right Shifter with Carry and Condition Field

This block shifts a 64-bit integer right arithmetically and reports whether a negative value lost any 1-bits. It works in one of two operand modes. In doubleword mode it shifts the whole 64-bit source. In word mode it shifts only the low 32 bits and sign-extends the 32-bit result to 64 bits. The shift count comes either from the low bits of a register operand or from an immediate field.

Counts at or beyond the operand width do not wrap. They fill the result with copies of the sign bit. The carry is raised only when the source is negative and at least one 1-bit leaves the low end. When the record input is set, the block also returns a 4-bit condition field. This field holds a signed comparison of the 64-bit result against zero, plus a copy of the summary-overflow input.

The datapath is combinational. An optional output register stage is present by default. Instruction decode, the register file and pipeline control belong to the surrounding core.

Top module: `asr_carry_unit`

## Requirements
- R1: In doubleword mode (`word_mode_i`=0) the 7-bit count has bit 6 clear. The result is then the signed source shifted right by count[5:0], with vacated high positions filled with `src_i[63]`.
- R2: In doubleword mode a count with bit 6 set (64 to 127) makes all 64 result bits equal to `src_i[63]`.
- R3: In doubleword mode `carry_o` is `src_i[63]` AND the OR of every source bit shifted out of bit 0. For counts of 64 to 127 this is the OR of all 64 source bits.
- R4: In word mode (`word_mode_i`=1) only `src_i[31:0]` is shifted, and the sign is bit 31. Count bit 6 and `src_i[63:32]` have no effect. For counts 0 to 31, result bits 63:32 all equal result bit 31.
- R5: In word mode a count with bit 5 set (32 to 63, after dropping bit 6) makes all 64 result bits equal to `src_i[31]`. `carry_o` is then `src_i[31]` AND the OR of `src_i[31:0]`.
- R6: In word mode with counts 0 to 31, `carry_o` is `src_i[31]` AND the OR of the low-word bits shifted out of bit 0.
- R7: An effective count of zero returns the source unchanged (sign-extended low word in word mode) and forces `carry_o` to 0.
- R8: `use_imm_i`=1 takes the count from `amt_imm_i`. `use_imm_i`=0 takes it from `amt_reg_i[6:0]`. The unselected operand and `amt_reg_i[63:7]` have no effect.
- R9: `cond_we_o` follows `record_i`. When it is set, `cond_o` is {bit 3: result < 0, bit 2: result > 0, bit 1: result == 0, bit 0: `so_i`}, comparing the signed 64-bit result, and exactly one of bits 3:1 is set. When it is clear, `cond_o` is 0.
- R10: With `REG_OUT`=1 (default), every output appears one clock after its inputs. Reset (`rst_ni` low) drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Source operand |
| amt_reg_i | input | 64 | Register shift operand; low 7 bits used |
| amt_imm_i | input | 7 | Immediate shift count |
| use_imm_i | input | 1 | Select immediate count |
| word_mode_i | input | 1 | 1 = 32-bit word mode, 0 = doubleword |
| record_i | input | 1 | Request condition field |
| so_i | input | 1 | Summary-overflow bit copied into the field |
| result_o | output | 64 | Shifted result |
| carry_o | output | 1 | Negative value lost 1-bits |
| cond_o | output | 4 | Condition field {lt, gt, eq, so} |
| cond_we_o | output | 1 | Condition field valid |

## Verification
Every count from 0 to 127 is applied in both modes to six operands:
- zero and all-ones, which separate sign fill from data movement;
- a positive value, which must never carry;
- a negative value whose only low 1-bit is bit 0, which separates the carry at count 1 from the carry at count 0;
- a negative value with a long run of trailing zeros, which places the first carry at one exact count;
- a value whose upper word is positive but whose low word is negative, which tells whether word mode picks its sign from bit 31 or from bit 63.

The count selection is exercised by alternating between the register and immediate paths while the unselected path carries a different count and the register's high bits carry garbage. The record input toggles across the sweep, so the field is seen both present and zeroed.

// File: rtl/asr_pkg.sv
package asr_pkg;
  // condition field bit positions
  localparam int unsigned CF_LT = 3;
  localparam int unsigned CF_GT = 2;
  localparam int unsigned CF_EQ = 1;
  localparam int unsigned CF_SO = 0;
  localparam int unsigned CF_W  = 4;

  typedef enum logic {
    ASR_DWORD = 1'b0,
    ASR_WORD  = 1'b1
  } asr_mode_e;
endpackage

// File: rtl/asr_count_sel.sv
module asr_count_sel #(
  parameter int unsigned CNT_W = 7
) (
  input  logic [CNT_W-1:0] amt_reg_i,
  input  logic [CNT_W-1:0] amt_imm_i,
  input  logic             use_imm_i,
  output logic [CNT_W-1:0] cnt_o
);
  assign cnt_o = use_imm_i ? amt_imm_i : amt_reg_i;
endmodule

// File: rtl/asr_core.sv
module asr_core #(
  parameter int unsigned W    = 64,
  localparam int unsigned SH_W = $clog2(W),
  localparam int unsigned CW   = SH_W + 1
) (
  input  logic [W-1:0]  src_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  logic [SH_W-1:0] n;
  logic            sat;
  logic            sign;
  logic [2*W-1:0]  dbl;
  logic [W-1:0]    rot, keep_mask, lost_mask;

  assign n    = cnt_i[SH_W-1:0];
  assign sat  = cnt_i[SH_W];
  assign sign = src_i[W-1];

  // rotate right by n == rotate left by W-n
  assign dbl = {src_i, src_i} >> n;
  assign rot = dbl[W-1:0];

  always_comb begin
    if (sat) begin
      keep_mask = '0;
      lost_mask = '1;
    end else begin
      keep_mask = {W{1'b1}} >> n;
      lost_mask = ~({W{1'b1}} << n);
    end
  end

  assign res_o   = (rot & keep_mask) | ({W{sign}} & ~keep_mask);
  assign carry_o = sign & (|(src_i & lost_mask));
endmodule

// File: rtl/asr_cond.sv
module asr_cond #(
  parameter int unsigned W = 64
) (
  input  logic                   res_i,
  input  logic [W-1:0]           val_i,
  input  logic                   record_i,
  input  logic                   so_i,
  output logic [asr_pkg::CF_W-1:0] cond_o,
  output logic                   we_o
);
  logic lt, eq, gt;
  assign lt = res_i;
  assign eq = ~|val_i;
  assign gt = ~lt & ~eq;

  always_comb begin
    cond_o = '0;
    if (record_i) begin
      cond_o[asr_pkg::CF_LT] = lt;
      cond_o[asr_pkg::CF_GT] = gt;
      cond_o[asr_pkg::CF_EQ] = eq;
      cond_o[asr_pkg::CF_SO] = so_i;
    end
  end
  assign we_o = record_i;
endmodule

// File: rtl/asr_carry_unit.sv
module asr_carry_unit #(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned HW     = XLEN / 2,
  localparam int unsigned CNT_W  = $clog2(XLEN) + 1,
  localparam int unsigned HCNT_W = $clog2(HW) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [XLEN-1:0]          src_i,
  input  logic [XLEN-1:0]          amt_reg_i,
  input  logic [CNT_W-1:0]         amt_imm_i,
  input  logic                     use_imm_i,
  input  logic                     word_mode_i,
  input  logic                     record_i,
  input  logic                     so_i,
  output logic [XLEN-1:0]          result_o,
  output logic                     carry_o,
  output logic [asr_pkg::CF_W-1:0] cond_o,
  output logic                     cond_we_o
);
  import asr_pkg::*;

  logic [CNT_W-1:0]         cnt;
  logic [XLEN-1:0]          d_res;
  logic                     d_carry;
  logic [HW-1:0]            w_res;
  logic                     w_carry;
  logic [XLEN-1:0]          res_d;
  logic                     carry_d;
  logic [CF_W-1:0]          cond_d;
  logic                     we_d;
  asr_mode_e                mode;
  logic                     unused_amt_hi;

  assign unused_amt_hi = ^amt_reg_i[XLEN-1:CNT_W];
  assign mode = asr_mode_e'(word_mode_i);

  asr_count_sel #(.CNT_W(CNT_W)) u_sel (
    .amt_reg_i (amt_reg_i[CNT_W-1:0]),
    .amt_imm_i (amt_imm_i),
    .use_imm_i (use_imm_i),
    .cnt_o     (cnt)
  );

  asr_core #(.W(XLEN)) u_dword (
    .src_i   (src_i),
    .cnt_i   (cnt),
    .res_o   (d_res),
    .carry_o (d_carry)
  );

  // word path drops the top count bit
  asr_core #(.W(HW)) u_word (
    .src_i   (src_i[HW-1:0]),
    .cnt_i   (cnt[HCNT_W-1:0]),
    .res_o   (w_res),
    .carry_o (w_carry)
  );

  always_comb begin
    if (mode == ASR_WORD) begin
      res_d   = {{(XLEN-HW){w_res[HW-1]}}, w_res};
      carry_d = w_carry;
    end else begin
      res_d   = d_res;
      carry_d = d_carry;
    end
  end

  asr_cond #(.W(XLEN)) u_cond (
    .res_i    (res_d[XLEN-1]),
    .val_i    (res_d),
    .record_i (record_i),
    .so_i     (so_i),
    .cond_o   (cond_d),
    .we_o     (we_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          result_o  <= '0;
          carry_o   <= 1'b0;
          cond_o    <= '0;
          cond_we_o <= 1'b0;
        end else begin
          result_o  <= res_d;
          carry_o   <= carry_d;
          cond_o    <= cond_d;
          cond_we_o <= we_d;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign result_o  = res_d;
      assign carry_o   = carry_d;
      assign cond_o    = cond_d;
      assign cond_we_o = we_d;
    end
  endgenerate
endmodule

// File: rtl/asr_carry_unit_chk.sv
module asr_carry_unit_chk #(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned HW     = XLEN / 2,
  localparam int unsigned CNT_W  = $clog2(XLEN) + 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [XLEN-1:0]          src_i,
  input logic [XLEN-1:0]          amt_reg_i,
  input logic [CNT_W-1:0]         amt_imm_i,
  input logic                     use_imm_i,
  input logic                     word_mode_i,
  input logic                     record_i,
  input logic                     so_i,
  input logic [XLEN-1:0]          result_o,
  input logic                     carry_o,
  input logic [3:0]               cond_o,
  input logic                     cond_we_o
);
  logic [CNT_W-1:0] cnt_in;
  logic             zero_in;
  logic [XLEN-1:0]  q_src, a_src;
  logic             q_word, a_word, q_zero, a_zero, q_rec, a_rec, q_so, a_so;
  logic             q_vld, a_vld;
  logic             unused_chk;

  assign unused_chk = ^amt_reg_i[XLEN-1:CNT_W];
  assign cnt_in  = use_imm_i ? amt_imm_i : amt_reg_i[CNT_W-1:0];
  assign zero_in = word_mode_i ? (cnt_in[CNT_W-2:0] == '0) : (cnt_in == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_src <= '0; q_word <= 1'b0; q_zero <= 1'b0;
      q_rec <= 1'b0; q_so <= 1'b0; q_vld <= 1'b0;
    end else begin
      q_src <= src_i; q_word <= word_mode_i; q_zero <= zero_in;
      q_rec <= record_i; q_so <= so_i; q_vld <= 1'b1;
    end
  end

  // inputs aligned with the outputs they produce
  assign a_src  = REG_OUT ? q_src  : src_i;
  assign a_word = REG_OUT ? q_word : word_mode_i;
  assign a_zero = REG_OUT ? q_zero : zero_in;
  assign a_rec  = REG_OUT ? q_rec  : record_i;
  assign a_so   = REG_OUT ? q_so   : so_i;
  assign a_vld  = REG_OUT ? q_vld  : 1'b1;

  // R3
  carry_needs_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> result_o[XLEN-1]);

  // R4
  word_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld && a_word) |-> (result_o[XLEN-1:HW] == {(XLEN-HW){result_o[HW-1]}}));

  // R7
  zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld && a_zero) |-> (!carry_o && (a_word ?
      (result_o == {{(XLEN-HW){a_src[HW-1]}}, a_src[HW-1:0]}) : (result_o == a_src))));

  // R9
  cond_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_o |-> ($countones(cond_o[3:1]) == 1));

  // R9
  cond_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_we_o |-> (cond_o == 4'b0000));

  // R9
  cond_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_vld |-> (cond_we_o == a_rec && (!a_rec || cond_o[0] == a_so)));

  // R9
  cond_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_o |-> (cond_o[1] == (result_o == '0)));
endmodule

bind asr_carry_unit asr_carry_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .amt_reg_i(amt_reg_i),
  .amt_imm_i(amt_imm_i), .use_imm_i(use_imm_i), .word_mode_i(word_mode_i),
  .record_i(record_i), .so_i(so_i), .result_o(result_o), .carry_o(carry_o),
  .cond_o(cond_o), .cond_we_o(cond_we_o)
);

// File: tb/asr_carry_unit_test.sv
`timescale 1ns/1ps
module asr_carry_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic [63:0] amt_reg_i = '0;
  logic [6:0]  amt_imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic        word_mode_i = 1'b0;
  logic        record_i = 1'b0;
  logic        so_i = 1'b0;
  logic [63:0] result_o;
  logic        carry_o;
  logic [3:0]  cond_o;
  logic        cond_we_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  asr_carry_unit uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: shift, then shift back to detect lost bits
  function automatic void ref_model(input logic [63:0] s, input logic [6:0] c,
                                    input logic wm, output logic [63:0] r, output logic cy);
    logic [31:0] lo, r32;
    logic [5:0]  n;
    if (!wm) begin
      if (c[6]) begin
        r  = {64{s[63]}};
        cy = s[63] && (s != 64'd0);
      end else begin
        r  = 64'($signed(s) >>> c[5:0]);
        cy = s[63] && ((r << c[5:0]) != s);
      end
    end else begin
      lo = s[31:0];
      n  = c[5:0];
      if (n >= 6'd32) begin
        r32 = {32{lo[31]}};
        cy  = lo[31] && (lo != 32'd0);
      end else begin
        r32 = 32'($signed(lo) >>> n);
        cy  = lo[31] && ((r32 << n) != lo);
      end
      r = {{32{r32[31]}}, r32};
    end
  endfunction

  task automatic run_vec(input logic [63:0] s, input logic [6:0] c, input logic wm,
                         input logic imm, input logic rec, input logic so);
    logic [63:0] er;
    logic        ecy;
    logic [3:0]  ec;
    string       rt, ct;
    @(negedge clk_i);
    src_i       = s;
    word_mode_i = wm;
    use_imm_i   = imm;
    record_i    = rec;
    so_i        = so;
    // R8: the unselected path carries a different count, high reg bits garbage
    if (imm) begin
      amt_imm_i = c;
      amt_reg_i = {57'h0_A5A5_5A5A_C3C3, ~c};
    end else begin
      amt_imm_i = ~c;
      amt_reg_i = {{57{c[0]}} ^ 57'h1_2345_6789_ABCD, c};
    end
    ref_model(s, c, wm, er, ecy);
    ec = rec ? {$signed(er) < 0, $signed(er) > 0, er == 64'd0, so} : 4'b0000;
    if (wm) begin
      rt = (c[5:0] == 0) ? "R7/R4" : (c[5] ? "R5" : "R4");
      ct = (c[5:0] == 0) ? "R7" : (c[5] ? "R5" : "R6");
    end else begin
      rt = (c == 0) ? "R7/R1" : (c[6] ? "R2" : "R1");
      ct = (c == 0) ? "R7" : "R3";
    end
    @(negedge clk_i);
    chk($sformatf("%s/R8 result s=%h c=%0d", rt, s, c), result_o, er);
    chk($sformatf("%s carry s=%h c=%0d", ct, s, c), 64'(carry_o), 64'(ecy));
    chk($sformatf("R9 cond c=%0d", c), 64'({cond_we_o, cond_o}), 64'({rec, ec}));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] ops [6];
    ops[0] = 64'h0000_0000_0000_0000;
    ops[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    ops[2] = 64'h7F3C_0000_1234_8001;
    ops[3] = 64'h8000_0000_0000_0001;
    ops[4] = 64'hA5C3_0F00_F000_0000;
    ops[5] = 64'h0000_0001_8000_0001;
    src_i = 64'hDEAD_BEEF_0123_4567;
    record_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10 reset result", result_o, 64'd0);
    chk("R10 reset flags", 64'({carry_o, cond_we_o, cond_o}), 64'd0);
    rst_ni = 1'b1;
    for (int wm = 0; wm < 2; wm++) begin
      for (int o = 0; o < 6; o++) begin
        for (int c = 0; c < 128; c++) begin
          run_vec(ops[o], 7'(c), wm[0], c[0], c[1] ^ o[0], c[2]);
        end
      end
    end
    // R10: one-cycle latency, result held until next edge
    @(negedge clk_i);
    src_i = 64'h8000_0000_0000_0000; word_mode_i = 1'b0; use_imm_i = 1'b1;
    amt_imm_i = 7'd4; record_i = 1'b0;
    @(posedge clk_i); #1;
    src_i = 64'h0;
    @(negedge clk_i);
    chk("R10 latency", result_o, 64'hF800_0000_0000_0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule